// File: doc/BRIEF.md
# Regulator Fault and Sequencing Supervisor

This block is the digital supervisor that sits beside a multiphase buck regulator controller. It takes already-digitized comparator flags for supply level, enable, output overvoltage, summed overcurrent, reference undervoltage, output window, power-loss sense and the soft-start ramp threshold, plus the 6-bit voltage identification code. From these it decides whether the PWM phases may switch, whether the external gate drivers are enabled, when the output is reported good, and when the soft-start capacitor must be discharged.

Each fault class has its own effect and its own way out: some latch until the supply falls below the power-on-reset level (the asynchronous `por_n` input), the voltage-identification shutdown lasts only while the code reads 11111x, enable has no memory, and the power-loss sense flag changes nothing. Power-good is qualified by a cycle counter set by a parameter. Every output is registered, so a change on an input sampled at a rising clock edge shows on the outputs right after that same edge.

Top module: `vr_supervisor`

## Requirements
- R1: `pgood` goes high right after the `PG_DLY_CYC`-th consecutive rising edge at which `vout_in_win` is high, and not before.
- R2: `pgood` goes low right after the first edge that samples `vout_in_win` low, and the qualification count then starts again from zero.
- R3: The supply lockout has hysteresis. After `uv_fall` is seen low, phases stay off until `uv_rise` is seen high. While `uv_fall` stays high with `uv_rise` low, a running converter keeps switching.
- R4: After every stop condition has cleared, `gate_en` stays all zeros until `ss_reached` is sampled high, and then turns all ones. `gate_en` is never a mix of ones and zeros.
- R5: A single-cycle `ovc` pulse turns the phases off and drives `drv_en` low. This state survives toggling `en` and clears only through `por_n`.
- R6: A `vid` code whose upper five bits are all ones (bit 0 ignored) turns the phases off, asserts `ss_dis` and drives `drv_en` low. Any other code removes the condition on the next edge.
- R7: After `por_n` rises, `drv_en` is high until `uv_rise` is first seen. It then follows `en`, staying low while `en` is low unless an overvoltage is latched.
- R8: A single-cycle `ovp` pulse turns the phases off and forces `drv_en` high, even when `en` is low in the same cycle. This state clears only through `por_n`.
- R9: `en` low turns the phases off and drives `drv_en` low. When `en` returns high the converter restarts through the soft-start hold of R4, with no latched state.
- R10: A `ref_uv` pulse turns the phases off and holds `pgood` low whatever `vout_in_win` does, including on the edge that would have completed qualification. The condition clears only through `por_n`.
- R11: `pwr_loss_oor` has no effect on `gate_en`, `drv_en`, `pgood` or `ss_dis`.
- R12: `ss_dis` is high exactly when any stop-switching condition is active: lockout, enable low, a latched overvoltage, overcurrent or reference fault, or a shutdown VID code.
- R13: While `por_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Supply above power-on-reset level; low clears everything asynchronously |
| uv_rise | input | 1 | Supply above the upper lockout threshold |
| uv_fall | input | 1 | Supply above the lower lockout threshold |
| en | input | 1 | Regulator enable |
| ovp | input | 1 | Output overvoltage flag |
| ovc | input | 1 | Summed phase current above limit |
| ref_uv | input | 1 | Reference undervoltage flag |
| vout_in_win | input | 1 | Output inside its power-good window |
| ss_reached | input | 1 | Soft-start/compensation ramp past its release level |
| pwr_loss_oor | input | 1 | Power-loss sense out of range |
| vid | input | VID_W | Voltage identification code |
| gate_en | output | NPH | Per-phase switching permission |
| drv_en | output | 1 | Enable for the external gate drivers |
| pgood | output | 1 | Qualified power-good |
| ss_dis | output | 1 | Request to discharge soft-start |

## Verification
The dangerous coincidence is a reference undervoltage arriving on the very edge at which the power-good counter completes. Qualification and the fault then fall in the same cycle, and the fault must win. The bench holds the window for one cycle less than the delay, raises `ref_uv` on the final qualifying edge, and expects `pgood` to stay low. A second collision, overvoltage together with enable low, pulls `drv_en` in opposite directions. It is provoked in one cycle and judged by `drv_en` reading high.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    typedef enum logic [0:0] {
        SS_HOLD = 1'b0,
        SS_RUN  = 1'b1
    } ss_state_e;

    // fault vector bit positions
    localparam int unsigned F_PLS   = 0;
    localparam int unsigned F_OVP   = 1;
    localparam int unsigned F_OVC   = 2;
    localparam int unsigned F_REFUV = 3;
    localparam int unsigned F_VID   = 4;
    localparam int unsigned NFLT    = 5;

    // per-class effect masks
    localparam logic [NFLT-1:0] STOP_MASK    = 5'b11110;
    localparam logic [NFLT-1:0] DRV_HI_MASK  = 5'b00010;
    localparam logic [NFLT-1:0] DRV_LO_MASK  = 5'b11100;

    typedef struct packed {
        logic uvlo_ok;
        logic seen_uvlo;
        logic ovp;
        logic ovc;
        logic refuv;
    } flt_state_t;

    typedef struct packed {
        logic drv_en;
        logic pgood;
        logic ss_dis;
    } out_state_t;

endpackage

// File: rtl/vrs_fault_core.sv
module vrs_fault_core
    import vrs_pkg::*;
#(
    parameter int unsigned VID_W = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             uv_rise,
    input  logic             uv_fall,
    input  logic             en,
    input  logic             ovp,
    input  logic             ovc,
    input  logic             ref_uv,
    input  logic             pwr_loss_oor,
    input  logic [VID_W-1:0] vid,
    output logic             stop_o,
    output logic             drv_o,
    output logic             refuv_o
);

    flt_state_t f_d, f_q;
    logic [NFLT-1:0] flt_vec;
    logic            vid_off;

    always_comb begin
        f_d = f_q;
        if (!uv_fall) begin
            f_d.uvlo_ok = 1'b0;
        end else if (uv_rise) begin
            f_d.uvlo_ok = 1'b1;
        end
        if (uv_rise) begin
            f_d.seen_uvlo = 1'b1;
        end
        f_d.ovp   = f_q.ovp   | ovp;
        f_d.ovc   = f_q.ovc   | ovc;
        f_d.refuv = f_q.refuv | ref_uv;

        vid_off = &vid[VID_W-1:1];

        flt_vec          = '0;
        flt_vec[F_PLS]   = pwr_loss_oor;
        flt_vec[F_OVP]   = f_d.ovp;
        flt_vec[F_OVC]   = f_d.ovc;
        flt_vec[F_REFUV] = f_d.refuv;
        flt_vec[F_VID]   = vid_off;

        stop_o  = !f_d.uvlo_ok || !en || (|(flt_vec & STOP_MASK));
        drv_o   = (|(flt_vec & DRV_HI_MASK)) || !f_d.seen_uvlo
                  || (en && f_d.uvlo_ok && !(|(flt_vec & DRV_LO_MASK)));
        refuv_o = f_d.refuv;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/vrs_ss_seq.sv
module vrs_ss_seq
    import vrs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic stop_i,
    input  logic ss_reached,
    output logic run_o
);

    ss_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d = SS_HOLD;
        end else if (st_q == SS_HOLD && ss_reached) begin
            st_d = SS_RUN;
        end
        run_o = (st_d == SS_RUN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= SS_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vrs_pg_timer.sv
module vrs_pg_timer #(
    parameter int unsigned DLY_CYC = 250000
) (
    input  logic clk,
    input  logic por_n,
    input  logic win_ok,
    output logic qual_o
);

    localparam int unsigned CW = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(DLY_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!win_ok) begin
            cnt_d = '0;
        end else if (cnt_q == LIM) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        qual_o = (cnt_d == LIM);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/vr_supervisor.sv
module vr_supervisor
    import vrs_pkg::*;
#(
    parameter int unsigned NPH        = 4,
    parameter int unsigned VID_W      = 6,
    parameter int unsigned PG_DLY_CYC = 250000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             uv_rise,
    input  logic             uv_fall,
    input  logic             en,
    input  logic             ovp,
    input  logic             ovc,
    input  logic             ref_uv,
    input  logic             vout_in_win,
    input  logic             ss_reached,
    input  logic             pwr_loss_oor,
    input  logic [VID_W-1:0] vid,
    output logic [NPH-1:0]   gate_en,
    output logic             drv_en,
    output logic             pgood,
    output logic             ss_dis
);

    logic stop, drv_next, refuv_act, run_next, pg_qual;
    logic [NPH-1:0] gate_d, gate_q;
    out_state_t o_d, o_q;

    vrs_fault_core #(.VID_W(VID_W)) u_core (
        .clk          (clk),
        .por_n        (por_n),
        .uv_rise      (uv_rise),
        .uv_fall      (uv_fall),
        .en           (en),
        .ovp          (ovp),
        .ovc          (ovc),
        .ref_uv       (ref_uv),
        .pwr_loss_oor (pwr_loss_oor),
        .vid          (vid),
        .stop_o       (stop),
        .drv_o        (drv_next),
        .refuv_o      (refuv_act)
    );

    vrs_ss_seq u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .stop_i     (stop),
        .ss_reached (ss_reached),
        .run_o      (run_next)
    );

    vrs_pg_timer #(.DLY_CYC(PG_DLY_CYC)) u_pg (
        .clk    (clk),
        .por_n  (por_n),
        .win_ok (vout_in_win && !refuv_act),
        .qual_o (pg_qual)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign gate_d[p] = run_next;
    end

    always_comb begin
        o_d        = o_q;
        o_d.drv_en = drv_next;
        o_d.pgood  = pg_qual;
        o_d.ss_dis = stop;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            o_q    <= '0;
            gate_q <= '0;
        end else begin
            o_q    <= o_d;
            gate_q <= gate_d;
        end
    end

    assign gate_en = gate_q;
    assign drv_en  = o_q.drv_en;
    assign pgood   = o_q.pgood;
    assign ss_dis  = o_q.ss_dis;

endmodule

// File: rtl/vr_supervisor_chk.sv
module vr_supervisor_chk #(
    parameter int unsigned NPH   = 4,
    parameter int unsigned VID_W = 6
) (
    input logic             clk,
    input logic             por_n,
    input logic             en,
    input logic             ovp,
    input logic             ovc,
    input logic             ref_uv,
    input logic             vout_in_win,
    input logic             ss_reached,
    input logic [VID_W-1:0] vid,
    input logic [NPH-1:0]   gate_en,
    input logic             drv_en,
    input logic             pgood,
    input logic             ss_dis
);

    // R1
    pg_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pgood) |-> $past(vout_in_win));

    // R2
    pg_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        !vout_in_win |=> !pgood);

    // R4
    gate_uniform_chk: assert property (@(posedge clk) disable iff (!por_n)
        (gate_en == '0) || (gate_en == '1));

    // R4
    gate_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(gate_en[0]) |-> $past(ss_reached));

    // R5
    ovc_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovc |=> (gate_en == '0) && ss_dis);

    // R6
    vid_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        (&vid[VID_W-1:1]) |=> (gate_en == '0) && ss_dis);

    // R8
    ovp_drv_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovp |=> drv_en && (gate_en == '0));

    // R9
    en_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        !en |=> (gate_en == '0));

    // R10
    refuv_pg_chk: assert property (@(posedge clk) disable iff (!por_n)
        ref_uv |=> !pgood && (gate_en == '0));

    // R12
    ss_dis_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        ss_dis |-> (gate_en == '0));

endmodule

bind vr_supervisor vr_supervisor_chk #(.NPH(NPH), .VID_W(VID_W)) u_chk (.*);

// File: tb/vr_supervisor_bench.sv
module vr_supervisor_bench;

    localparam int unsigned NPH = 4;
    localparam int unsigned VW  = 6;
    localparam int unsigned DLY = 6;
    localparam logic [NPH-1:0] ONES = '1;

    logic clk = 1'b0;
    logic por_n, uv_rise, uv_fall, en, ovp, ovc, ref_uv;
    logic vout_in_win, ss_reached, pwr_loss_oor;
    logic [VW-1:0] vid;
    logic [NPH-1:0] gate_en;
    logic drv_en, pgood, ss_dis;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vr_supervisor #(.NPH(NPH), .VID_W(VW), .PG_DLY_CYC(DLY)) u_vr_supervisor (
        .clk(clk), .por_n(por_n), .uv_rise(uv_rise), .uv_fall(uv_fall),
        .en(en), .ovp(ovp), .ovc(ovc), .ref_uv(ref_uv),
        .vout_in_win(vout_in_win), .ss_reached(ss_reached),
        .pwr_loss_oor(pwr_loss_oor), .vid(vid),
        .gate_en(gate_en), .drv_en(drv_en), .pgood(pgood), .ss_dis(ss_dis)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic outs(input string req, input logic [NPH-1:0] g, input logic d,
                        input logic p, input logic s);
        check(req, {gate_en, drv_en, pgood, ss_dis}, {g, d, p, s});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic power_up();
        por_n = 1'b0; uv_rise = 0; uv_fall = 0; en = 0; ovp = 0; ovc = 0;
        ref_uv = 0; vout_in_win = 0; ss_reached = 0; pwr_loss_oor = 0; vid = '0;
        step();
        por_n = 1'b1;
        step();
        uv_rise = 1; uv_fall = 1; en = 1;
        step();
        ss_reached = 1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
        $finish;
    end

    initial begin
        por_n = 1'b0; uv_rise = 0; uv_fall = 0; en = 0; ovp = 0; ovc = 0;
        ref_uv = 0; vout_in_win = 0; ss_reached = 0; pwr_loss_oor = 0; vid = '0;
        step();
        step();
        outs("R13 reset", '0, 0, 0, 0);

        // power-up window of the driver enable
        por_n = 1'b1;
        step();
        outs("R7 pre-lockout drv high", '0, 1, 0, 1);
        uv_fall = 1;
        step();
        outs("R3 fall flag alone keeps lockout", '0, 1, 0, 1);
        uv_rise = 1;
        step();
        outs("R7 drv low after lockout with en low", '0, 0, 0, 1);

        en = 1;
        step();
        outs("R4 held low before ramp", '0, 1, 0, 0);
        step();
        outs("R12 no stop while held", '0, 1, 0, 0);
        ss_reached = 1;
        step();
        outs("R4 release on ramp", ONES, 1, 0, 0);

        // hysteresis
        uv_rise = 0;
        step();
        outs("R3 running between thresholds", ONES, 1, 0, 0);
        uv_fall = 0;
        step();
        outs("R3 below lower threshold", '0, 0, 0, 1);
        uv_fall = 1;
        step();
        outs("R3 stays locked until rise", '0, 0, 0, 1);
        uv_rise = 1;
        step();
        outs("R3 restart after rise", ONES, 1, 0, 0);

        // VID sweep
        for (int c = 0; c < 64; c++) begin
            logic off;
            vid = VW'(c);
            off = ((c >> 1) == 31);
            step();
            outs("R6 vid sweep", off ? '0 : ONES, !off, 0, off);
        end
        vid = 6'd5;
        step();
        outs("R6 vid clears on change", ONES, 1, 0, 0);

        // enable has no memory
        en = 0;
        step();
        outs("R9 en low", '0, 0, 0, 1);
        en = 1; ss_reached = 0;
        step();
        outs("R9 en back holds for ramp", '0, 1, 0, 0);
        ss_reached = 1;
        step();
        outs("R9 recovered", ONES, 1, 0, 0);

        // power-good window sweep
        for (int len = 1; len <= int'(DLY) + 2; len++) begin
            vout_in_win = 1;
            for (int k = 1; k <= len; k++) begin
                step();
                check("R1 pgood qualification", {31'd0, pgood}, {31'd0, (k >= int'(DLY))});
            end
            vout_in_win = 0;
            step();
            check("R2 pgood drop", {31'd0, pgood}, 32'd0);
        end

        // power-loss sense has no effect
        vout_in_win = 1;
        repeat (DLY) step();
        outs("R1 pgood settled", ONES, 1, 1, 0);
        pwr_loss_oor = 1;
        step();
        outs("R11 pls asserted", ONES, 1, 1, 0);
        step();
        outs("R11 pls held", ONES, 1, 1, 0);
        pwr_loss_oor = 0;
        step();
        outs("R11 pls released", ONES, 1, 1, 0);

        // reference fault
        ref_uv = 1;
        step();
        outs("R10 ref fault", '0, 0, 0, 1);
        ref_uv = 0;
        repeat (DLY + 1) step();
        outs("R10 latched, window ignored", '0, 0, 0, 1);

        // coincidence: ref fault on the qualifying edge
        power_up();
        outs("R10 cleared by por", ONES, 1, 0, 0);
        vout_in_win = 1;
        repeat (DLY - 1) step();
        check("R1 not yet qualified", {31'd0, pgood}, 32'd0);
        ref_uv = 1;
        step();
        outs("R10 fault beats qualification", '0, 0, 0, 1);
        ref_uv = 0;

        // overcurrent latch
        power_up();
        ovc = 1;
        step();
        outs("R5 ovc trip", '0, 0, 0, 1);
        ovc = 0; en = 0;
        step();
        en = 1;
        step();
        step();
        outs("R5 survives en toggle", '0, 0, 0, 1);
        power_up();
        outs("R5 cleared by por", ONES, 1, 0, 0);

        // overvoltage with enable low in the same cycle
        ovp = 1; en = 0;
        step();
        outs("R8 ovp beats en low", '0, 1, 0, 1);
        ovp = 0;
        step();
        outs("R8 ovp latched", '0, 1, 0, 1);
        en = 1;
        step();
        outs("R8 ovp survives en", '0, 1, 0, 1);
        power_up();
        outs("R8 cleared by por", ONES, 1, 0, 0);

        summary();
        $finish;
    end

endmodule